// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the network-layer controller of a 1-Wire slave. It sits between the bit transceiver, which detects reset pulses and time slots, and the memory-function logic. After each bus reset it gathers eight slots into a command byte, least significant bit first, and runs the selection sequence that byte names. The block can serve its 64-bit identification code, compare the code against one the master sends, or take part in search arbitration. It also sets the transceiver speed and tracks whether the device may be re-selected with Resume.

The transceiver tells the block about each slot with a one-cycle strobe and the sampled line level. Ahead of every slot the block states whether that slot is one it drives (`tx_en`) and which level it will leave on the wired-AND line (`tx_bit`). Memory-function access is granted through `mem_en` and lasts until the next bus reset.

Top module: `onewire_rom_layer`

## Requirements
- R1: After power-up reset, and in the cycle after every bus reset, `mem_en` and `tx_en` are 0. The next eight slots form a command byte, least significant bit first. A bus reset aborts any sequence that is running.
- R2: Command 0x33 turns the next 64 slots into device-driven slots that present `rom_id` bit 0 first. After the 64th slot `mem_en` is 1.
- R3: Command 0x55 compares the next 64 written slots with `rom_id`, bit 0 first. If every bit matches, `mem_en` is 1. On the first differing bit the block goes idle until the next bus reset: `mem_en` and `tx_en` are 0.
- R4: Command 0xF0 uses three slots per code bit. The device drives the bit, then its complement, then reads the master's choice. A choice that differs from the bit sends the block idle. After all 64 bits `mem_en` is 1.
- R5: Command 0xEC behaves as 0xF0 when `alarm` is 1 at the last command slot. When `alarm` is 0 the block goes idle and drives no slot.
- R6: Command 0xCC sets `mem_en` right after the command byte.
- R7: Command 0x3C or 0x69 sets `od_mode` to 1 when the byte ends. The block then acts as 0xCC or 0x55. When either byte arrives while already in overdrive, `od_mode` stays 1.
- R8: A bus reset with `rst_std` at 1 clears `od_mode`. A bus reset with `rst_std` at 0 leaves `od_mode` unchanged.
- R9: A resume flag is set by a completed match or search. It is cleared by a failed match, a lost search, 0xEC with `alarm` at 0, and by 0xCC or 0x3C. Command 0xA5 sets `mem_en` only while the flag is set; otherwise the block goes idle.
- R10: Any other command byte sends the block idle: `mem_en` and `tx_en` are 0.
- R11: While idle or granted, slots have no effect on the block. Whenever `tx_en` is 0, `tx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst | input | 1 | One-cycle strobe: reset pulse detected on the bus |
| rst_std | input | 1 | The detected reset pulse had standard length |
| slot_stb | input | 1 | One-cycle strobe: a time slot completed |
| slot_bit | input | 1 | Line level sampled in that slot |
| alarm | input | 1 | Alarm condition for conditional search |
| rom_id | input | 64 | Identification code of the device |
| tx_en | output | 1 | Next slot is driven by the device |
| tx_bit | output | 1 | Level the device leaves on the line in that slot |
| od_mode | output | 1 | Transceiver runs at overdrive speed |
| mem_en | output | 1 | Memory-function layer enabled |

## Verification
A wrong sequence state becomes visible at the very next slot. `tx_en` rises where the master expects to write, or falls where the scoreboard expects a code bit, so the first wrong bit is caught in the slot where it happens. A wrong bit counter shows up as a misaligned code bit, or as `mem_en` rising early or late around the 64th slot. A stale resume flag or speed flag only becomes visible later: a Resume or a reset of a given length is needed to expose it, and the bench issues one right after each selection case.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_MEM
    } owr_state_e;

    typedef enum logic [3:0] {
        OP_READ,
        OP_MATCH,
        OP_SRCH,
        OP_CSRCH,
        OP_SKIP,
        OP_OD_SKIP,
        OP_OD_MATCH,
        OP_RESUME,
        OP_BAD
    } owr_op_e;

    localparam logic [7:0] CODE_READ     = 8'h33;
    localparam logic [7:0] CODE_MATCH    = 8'h55;
    localparam logic [7:0] CODE_SRCH     = 8'hF0;
    localparam logic [7:0] CODE_CSRCH    = 8'hEC;
    localparam logic [7:0] CODE_SKIP     = 8'hCC;
    localparam logic [7:0] CODE_OD_SKIP  = 8'h3C;
    localparam logic [7:0] CODE_OD_MATCH = 8'h69;
    localparam logic [7:0] CODE_RESUME   = 8'hA5;

endpackage

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
    import owr_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd_byte,
    output owr_op_e          op
);
    always_comb begin
        case (cmd_byte)
            CMD_W'(CODE_READ):     op = OP_READ;
            CMD_W'(CODE_MATCH):    op = OP_MATCH;
            CMD_W'(CODE_SRCH):     op = OP_SRCH;
            CMD_W'(CODE_CSRCH):    op = OP_CSRCH;
            CMD_W'(CODE_SKIP):     op = OP_SKIP;
            CMD_W'(CODE_OD_SKIP):  op = OP_OD_SKIP;
            CMD_W'(CODE_OD_MATCH): op = OP_OD_MATCH;
            CMD_W'(CODE_RESUME):   op = OP_RESUME;
            default:               op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/owr_id_mux.sv
module owr_id_mux #(
    parameter int ID_W  = 64,
    parameter int IDX_W = $clog2(ID_W)
) (
    input  logic [ID_W-1:0]  id,
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);
    logic [ID_W-1:0] hit;

    for (genvar g = 0; g < ID_W; g++) begin : g_sel
        assign hit[g] = id[g] & (idx == IDX_W'(g));
    end

    assign id_bit = |hit;
endmodule

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer
    import owr_pkg::*;
#(
    parameter int ID_W  = 64,
    parameter int CMD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rst,
    input  logic            rst_std,
    input  logic            slot_stb,
    input  logic            slot_bit,
    input  logic            alarm,
    input  logic [ID_W-1:0] rom_id,
    output logic            tx_en,
    output logic            tx_bit,
    output logic            od_mode,
    output logic            mem_en
);
    localparam int IDX_W = ($clog2(ID_W) > $clog2(CMD_W)) ? $clog2(ID_W) : $clog2(CMD_W);
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

    typedef struct packed {
        owr_state_e       st;
        logic [IDX_W-1:0] cnt;
        logic [1:0]       ph;
        logic [CMD_W-1:0] sh;
        logic             od;
        logic             res;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CMD_W-1:0] cmd_next;
    owr_op_e          op;
    logic             id_bit;

    assign cmd_next = {slot_bit, ctl_q.sh[CMD_W-1:1]};

    owr_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd_byte (cmd_next),
        .op       (op)
    );

    owr_id_mux #(.ID_W(ID_W), .IDX_W(IDX_W)) u_mux (
        .id     (rom_id),
        .idx    (ctl_q.cnt),
        .id_bit (id_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (bus_rst) begin
            ctl_d.st  = ST_CMD;
            ctl_d.cnt = '0;
            ctl_d.ph  = '0;
            if (rst_std) ctl_d.od = 1'b0;
        end else if (slot_stb) begin
            case (ctl_q.st)
                ST_CMD: begin
                    ctl_d.sh  = cmd_next;
                    ctl_d.cnt = ctl_q.cnt + IDX_W'(1);
                    if (ctl_q.cnt == CMD_LAST) begin
                        ctl_d.cnt = '0;
                        ctl_d.ph  = '0;
                        case (op)
                            OP_READ:  ctl_d.st = ST_READ;
                            OP_MATCH: ctl_d.st = ST_MATCH;
                            OP_OD_MATCH: begin
                                ctl_d.st = ST_MATCH;
                                ctl_d.od = 1'b1;
                            end
                            OP_SRCH:  ctl_d.st = ST_SRCH;
                            OP_CSRCH: begin
                                if (alarm) begin
                                    ctl_d.st = ST_SRCH;
                                end else begin
                                    ctl_d.st  = ST_IDLE;
                                    ctl_d.res = 1'b0;
                                end
                            end
                            OP_SKIP: begin
                                ctl_d.st  = ST_MEM;
                                ctl_d.res = 1'b0;
                            end
                            OP_OD_SKIP: begin
                                ctl_d.st  = ST_MEM;
                                ctl_d.res = 1'b0;
                                ctl_d.od  = 1'b1;
                            end
                            OP_RESUME: ctl_d.st = ctl_q.res ? ST_MEM : ST_IDLE;
                            default:   ctl_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: begin
                    if (ctl_q.cnt == ID_LAST) ctl_d.st = ST_MEM;
                    else ctl_d.cnt = ctl_q.cnt + IDX_W'(1);
                end
                ST_MATCH: begin
                    if (slot_bit != id_bit) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.res = 1'b0;
                    end else if (ctl_q.cnt == ID_LAST) begin
                        ctl_d.st  = ST_MEM;
                        ctl_d.res = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + IDX_W'(1);
                    end
                end
                ST_SRCH: begin
                    if (ctl_q.ph != 2'd2) begin
                        ctl_d.ph = ctl_q.ph + 2'd1;
                    end else if (slot_bit != id_bit) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.res = 1'b0;
                    end else begin
                        ctl_d.ph = '0;
                        if (ctl_q.cnt == ID_LAST) begin
                            ctl_d.st  = ST_MEM;
                            ctl_d.res = 1'b1;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + IDX_W'(1);
                        end
                    end
                end
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.cnt <= '0;
            ctl_q.ph  <= '0;
            ctl_q.sh  <= '0;
            ctl_q.od  <= 1'b0;
            ctl_q.res <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        tx_en  = 1'b0;
        tx_bit = 1'b1;
        if (ctl_q.st == ST_READ) begin
            tx_en  = 1'b1;
            tx_bit = id_bit;
        end else if (ctl_q.st == ST_SRCH && ctl_q.ph != 2'd2) begin
            tx_en  = 1'b1;
            tx_bit = (ctl_q.ph == 2'd0) ? id_bit : ~id_bit;
        end
    end

    assign od_mode = ctl_q.od;
    assign mem_en  = (ctl_q.st == ST_MEM);

endmodule

// File: rtl/onewire_rom_layer_chk.sv
module onewire_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic rst_std,
    input logic slot_stb,
    input logic tx_en,
    input logic tx_bit,
    input logic od_mode,
    input logic mem_en
);
    assert_rst_revokes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!mem_en && !tx_en));

    assert_grant_at_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |-> $past(slot_stb) && !$past(bus_rst));

    assert_od_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_mode) |-> $past(slot_stb) && !$past(bus_rst));

    assert_od_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_mode) |-> $past(bus_rst) && $past(rst_std));

    assert_std_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && rst_std) |=> !od_mode);

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_bit);

    assert_no_drive_when_granted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !tx_en);
endmodule

bind onewire_rom_layer onewire_rom_layer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .rst_std  (rst_std),
    .slot_stb (slot_stb),
    .tx_en    (tx_en),
    .tx_bit   (tx_bit),
    .od_mode  (od_mode),
    .mem_en   (mem_en)
);

// File: tb/sim_onewire_rom_layer.sv
module sim_onewire_rom_layer;
    localparam int CLK_P = 10;
    localparam logic [63:0] ID = 64'h8D00_0012_3456_7828;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0, rst_std = 1'b0, slot_stb = 1'b0, slot_bit = 1'b1, alarm = 1'b0;
    logic [63:0] rom_id = ID;
    logic tx_en, tx_bit, od_mode, mem_en;

    int nvec = 0;
    int nerr = 0;
    bit exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    onewire_rom_layer u0 (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rst_std(rst_std),
        .slot_stb(slot_stb), .slot_bit(slot_bit), .alarm(alarm), .rom_id(rom_id),
        .tx_en(tx_en), .tx_bit(tx_bit), .od_mode(od_mode), .mem_en(mem_en)
    );

    // monitor: each device-driven slot must present the next queued bit
    always @(negedge clk) begin
        if (rst_n && slot_stb && tx_en) begin
            nvec++;
            if (exp_q.size() == 0) begin
                nerr++;
                $display("FAIL R2/R4 unexpected driven slot: got %0b expected none", tx_bit);
            end else begin
                automatic bit e = exp_q.pop_front();
                if (tx_bit !== e) begin
                    nerr++;
                    $display("FAIL R2/R4 driven bit: got %0b expected %0b", tx_bit, e);
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic breset(bit std);
        @(posedge clk); #1;
        bus_rst = 1'b1; rst_std = std;
        @(posedge clk); #1;
        bus_rst = 1'b0; rst_std = 1'b0;
    endtask

    task automatic wslot(bit b);
        @(posedge clk); #1;
        slot_bit = b; slot_stb = 1'b1;
        @(posedge clk); #1;
        slot_stb = 1'b0; slot_bit = 1'b1;
    endtask

    task automatic rslot();
        @(posedge clk); #1;
        slot_bit = tx_en ? tx_bit : 1'b1;
        slot_stb = 1'b1;
        @(posedge clk); #1;
        slot_stb = 1'b0; slot_bit = 1'b1;
    endtask

    task automatic sbyte(logic [7:0] b);
        for (int i = 0; i < 8; i++) wslot(b[i]);
    endtask

    task automatic match_id(logic [63:0] v);
        for (int i = 0; i < 64; i++) wslot(v[i]);
    endtask

    // search; lose_at < 64 writes the wrong choice at that bit and stops
    task automatic search(int lose_at);
        for (int i = 0; i < 64; i++) begin
            exp_q.push_back(ID[i]);
            exp_q.push_back(~ID[i]);
            rslot();
            rslot();
            if (i == lose_at) begin
                wslot(~ID[i]);
                return;
            end
            wslot(ID[i]);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mem_en", 64'(mem_en), 0);
        chk("R1 reset tx_en", 64'(tx_en), 0);
        chk("R11 reset tx_bit", 64'(tx_bit), 1);
        chk("R8 reset od", 64'(od_mode), 0);

        // R2 read
        breset(1);
        chk("R1 after bus reset", 64'(mem_en), 0);
        sbyte(8'h33);
        chk("R2 drives after cmd", 64'(tx_en), 1);
        for (int i = 0; i < 64; i++) begin exp_q.push_back(ID[i]); rslot(); end
        chk("R2 granted", 64'(mem_en), 1);
        wslot(0); wslot(1);
        chk("R11 slots ignored when granted", {62'd0, mem_en, tx_en}, 64'd2);

        // R9 read leaves flag clear
        breset(1); sbyte(8'hA5);
        chk("R9 resume without flag", 64'(mem_en), 0);

        // R3 match
        breset(1); sbyte(8'h55); match_id(ID);
        chk("R3 match ok", 64'(mem_en), 1);
        breset(1); sbyte(8'hA5);
        chk("R9 resume after match", 64'(mem_en), 1);

        breset(1); sbyte(8'h55); match_id(ID ^ 64'h20);
        chk("R3 mismatch mem_en", 64'(mem_en), 0);
        chk("R3 mismatch tx_en", 64'(tx_en), 0);
        breset(1); sbyte(8'hA5);
        chk("R9 cleared by failed match", 64'(mem_en), 0);
        wslot(1);
        chk("R11 idle slot ignored", {62'd0, mem_en, tx_en}, 0);

        // R4 search
        breset(1); sbyte(8'hF0); search(64);
        chk("R4 search won", 64'(mem_en), 1);
        breset(1); sbyte(8'hA5);
        chk("R9 resume after search", 64'(mem_en), 1);
        breset(1); sbyte(8'hF0); search(3);
        chk("R4 lost tx_en", 64'(tx_en), 0);
        wslot(0);
        chk("R4 lost stays idle", {62'd0, mem_en, tx_en}, 0);
        breset(1); sbyte(8'hA5);
        chk("R9 cleared by lost search", 64'(mem_en), 0);

        // R5 conditional search
        alarm = 1'b0;
        breset(1); sbyte(8'hEC);
        chk("R5 no alarm silent", {62'd0, mem_en, tx_en}, 0);
        alarm = 1'b1;
        breset(1); sbyte(8'hEC); search(64);
        chk("R5 alarm search won", 64'(mem_en), 1);
        alarm = 1'b0;
        breset(1); sbyte(8'hEC);
        breset(1); sbyte(8'hA5);
        chk("R9 cleared by silent cond search", 64'(mem_en), 0);

        // R6 skip
        breset(1); sbyte(8'h55); match_id(ID);
        breset(1); sbyte(8'hCC);
        chk("R6 skip grants", 64'(mem_en), 1);
        breset(1); sbyte(8'hA5);
        chk("R9 cleared by skip", 64'(mem_en), 0);

        // R10 unknown byte
        breset(1); sbyte(8'h00);
        chk("R10 unknown", {62'd0, mem_en, tx_en}, 0);
        breset(1); sbyte(8'h96);
        chk("R10 unknown 2", {62'd0, mem_en, tx_en}, 0);

        // R7/R8 overdrive
        breset(1); sbyte(8'h3C);
        chk("R7 od skip speed", 64'(od_mode), 1);
        chk("R7 od skip grants", 64'(mem_en), 1);
        breset(0);
        chk("R8 short reset keeps od", 64'(od_mode), 1);
        sbyte(8'h69);
        chk("R7 od match at od", 64'(od_mode), 1);
        match_id(ID);
        chk("R7 od match grants", 64'(mem_en), 1);
        breset(1);
        chk("R8 std reset clears od", 64'(od_mode), 0);
        sbyte(8'h69);
        chk("R7 od match sets od", 64'(od_mode), 1);
        match_id(~ID);
        chk("R7 od match wrong id", 64'(mem_en), 0);
        breset(1);
        chk("R8 std reset clears od 2", 64'(od_mode), 0);

        // R1 reset aborts read
        breset(1); sbyte(8'h33);
        for (int i = 0; i < 5; i++) begin exp_q.push_back(ID[i]); rslot(); end
        breset(1);
        chk("R1 abort tx_en", 64'(tx_en), 0);
        sbyte(8'hCC);
        chk("R1 new command after abort", 64'(mem_en), 1);

        chk("R2 scoreboard drained", 64'(exp_q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule